// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation table from memory. A request carries the virtual address plus flags that mark it as a write and/or a user-mode access. The walker then reads a directory entry and a table entry, one after the other, through a single request/acknowledge memory port. It checks each entry for presence, reserved bits and access rights. It either returns the physical address or reports a fault. Every fault also loads a fault-address register with the virtual address that caused it.

Three control inputs steer the walk. Translation takes place only when both the paging-enable and the protection-enable bits are set; otherwise the address passes through unchanged and memory is not touched. The write-protect bit decides whether supervisor writes to read-only pages fault. After a walk succeeds, the walker writes back any entry whose accessed flag was clear, with that flag now set. The block handles one request at a time. The control inputs must stay stable while a walk is running.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read at `{dir_base_i, 12'h000} + 4*vaddr[31:22]`. The table entry is read at `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`. Every memory address the walker issues is 4-byte aligned.
- R2: When the walk succeeds, `rsp_fault_o` is 0 and `rsp_paddr_o` is `{table_entry[31:12], vaddr[11:0]}`.
- R3: If the directory entry has bit 0 (present) at 0, the response faults and the table entry is not read. If the table entry has bit 0 at 0, the response also faults. A faulting response carries `rsp_paddr_o` = 0.
- R4: If the reserved bit 7 is set in either entry, the response faults.
- R5: A user access (`req_user_i`=1) faults if bit 2 (user-allowed) is 0 in either entry. A supervisor access ignores bit 2.
- R6: A write to a page whose bit 1 (writable) is 0 in either entry faults for a user access. For a supervisor access it faults only when `wp_en_i`=1; with `wp_en_i`=0 the supervisor write succeeds.
- R7: `fault_addr_o` resets to 0. It loads the virtual address of each faulting request, at the latest when the response is presented, and it is left unchanged by successful or pass-through requests.
- R8: If `paging_en_i` or `protect_en_i` is 0, the response returns the virtual address unchanged with no fault, and the memory port is not used.
- R9: After a successful walk, each entry whose bit 5 (accessed) was 0 is written back with bit 5 set and its other bits unchanged. The directory entry is written before the table entry. Entries with bit 5 already set are not written. A fault causes no write.
- R10: `req_ready_o` is high only while the walker is idle. It drops in the cycle after a request is accepted. `rsp_valid_o` is a single-cycle pulse for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| paging_en_i | input | 1 | Paging enable control bit |
| protect_en_i | input | 1 | Protection enable control bit |
| wp_en_i | input | 1 | Write-protect for supervisor writes |
| dir_base_i | input | 20 | Directory base, physical address bits 31:12 |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write |
| req_user_i | input | 1 | Request comes from user mode |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Translated physical address |
| rsp_fault_o | output | 1 | Translation faulted |
| fault_addr_o | output | 32 | Virtual address of the latest fault |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The assertions check on every cycle that memory addresses are aligned to an entry, and that every write-back sets the accessed flag. They also check that a faulting response always shows its own virtual address in the fault-address register, that the walker is busy after it accepts a request, and that responses last one cycle. Only the bench's scenarios can show the rest. That covers the correct physical address, each fault cause at each level, and the write-protect distinction between supervisor and user writes. It also covers the pass-through path with no memory traffic, and the exact number and content of accessed-flag write-backs, which the bench checks against its own memory model.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_WB_DIR,
    ST_WB_TBL,
    ST_RESP
  } walk_state_e;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITE    = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_ACCESSED = 5;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SH     = 12,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [ADDR_W-PAGE_SH-1:0] base_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [ADDR_W-1:0]         addr_o
);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);

  assign addr_o = {base_i, {PAGE_SH{1'b0}}} + (ADDR_W'(idx_i) << ENTRY_SH);
endmodule

// File: rtl/pt_perm_chk.sv
module pt_perm_chk
  import pt_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] RSVD_MASK = 32'h0000_0080
) (
  input  logic [ADDR_W-1:0] entry_i,
  input  logic              write_i,
  input  logic              user_i,
  input  logic              wp_i,
  output logic              fault_o
);
  logic absent, rsvd, priv_bad, wr_bad;

  assign absent   = !entry_i[BIT_PRESENT];
  assign rsvd     = |(entry_i & ADDR_W'(RSVD_MASK));
  assign priv_bad = user_i && !entry_i[BIT_USER];
  // supervisor writes to read-only pages fault only under write-protect
  assign wr_bad   = write_i && !entry_i[BIT_WRITE] && (user_i || wp_i);
  assign fault_o  = absent || rsvd || priv_bad || wr_bad;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          PAGE_SH     = 12,
  parameter int          IDX_W       = 10,
  parameter int          ENTRY_BYTES = 4,
  parameter logic [31:0] RSVD_MASK   = 32'h0000_0080
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      paging_en_i,
  input  logic                      protect_en_i,
  input  logic                      wp_en_i,
  input  logic [ADDR_W-PAGE_SH-1:0] dir_base_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_vaddr_i,
  input  logic                      req_write_i,
  input  logic                      req_user_i,
  output logic                      rsp_valid_o,
  output logic [ADDR_W-1:0]         rsp_paddr_o,
  output logic                      rsp_fault_o,
  output logic [ADDR_W-1:0]         fault_addr_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [ADDR_W-1:0]         mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [ADDR_W-1:0]         mem_rdata_i
);
  localparam int LEVELS   = 2;
  localparam int FRAME_W  = ADDR_W - PAGE_SH;
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] ACC_SET = ADDR_W'(1) << BIT_ACCESSED;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] vaddr_q, dir_q, tbl_q, paddr_q, fault_addr_q;
  logic              write_q, user_q, fault_q;
  logic              chk_fault;

  logic [FRAME_W-1:0] lvl_base [LEVELS];
  logic [IDX_W-1:0]   lvl_idx  [LEVELS];
  logic [ADDR_W-1:0]  lvl_addr [LEVELS];

  assign lvl_base[0] = dir_base_i;
  assign lvl_base[1] = dir_q[ADDR_W-1:PAGE_SH];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign lvl_idx[l] = vaddr_q[PAGE_SH + (LEVELS-1-l)*IDX_W +: IDX_W];
    pt_addr_gen #(
      .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) i_addr_gen (
      .base_i(lvl_base[l]),
      .idx_i (lvl_idx[l]),
      .addr_o(lvl_addr[l])
    );
  end

  // entry under test is always the word just returned by memory
  pt_perm_chk #(.ADDR_W(ADDR_W), .RSVD_MASK(RSVD_MASK)) i_perm_chk (
    .entry_i(mem_rdata_i),
    .write_i(write_q),
    .user_i (user_q),
    .wp_i   (wp_en_i),
    .fault_o(chk_fault)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_RD_DIR: begin mem_req_o = 1'b1; mem_addr_o = lvl_addr[0]; end
      ST_RD_TBL: begin mem_req_o = 1'b1; mem_addr_o = lvl_addr[1]; end
      ST_WB_DIR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = lvl_addr[0]; mem_wdata_o = dir_q | ACC_SET;
      end
      ST_WB_TBL: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = lvl_addr[1]; mem_wdata_o = tbl_q | ACC_SET;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      vaddr_q      <= '0;
      write_q      <= 1'b0;
      user_q       <= 1'b0;
      dir_q        <= '0;
      tbl_q        <= '0;
      paddr_q      <= '0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          write_q <= req_write_i;
          user_q  <= req_user_i;
          if (paging_en_i && protect_en_i) begin
            state_q <= ST_RD_DIR;
          end else begin
            paddr_q <= req_vaddr_i;
            fault_q <= 1'b0;
            state_q <= ST_RESP;
          end
        end
        ST_RD_DIR: if (mem_ack_i) begin
          dir_q <= mem_rdata_i;
          if (chk_fault) begin
            fault_q      <= 1'b1;
            paddr_q      <= '0;
            fault_addr_q <= vaddr_q;
            state_q      <= ST_RESP;
          end else begin
            state_q <= ST_RD_TBL;
          end
        end
        ST_RD_TBL: if (mem_ack_i) begin
          tbl_q <= mem_rdata_i;
          if (chk_fault) begin
            fault_q      <= 1'b1;
            paddr_q      <= '0;
            fault_addr_q <= vaddr_q;
            state_q      <= ST_RESP;
          end else begin
            fault_q <= 1'b0;
            paddr_q <= {mem_rdata_i[ADDR_W-1:PAGE_SH], vaddr_q[PAGE_SH-1:0]};
            if (!dir_q[BIT_ACCESSED])             state_q <= ST_WB_DIR;
            else if (!mem_rdata_i[BIT_ACCESSED])  state_q <= ST_WB_TBL;
            else                                  state_q <= ST_RESP;
          end
        end
        ST_WB_DIR: if (mem_ack_i) state_q <= tbl_q[BIT_ACCESSED] ? ST_RESP : ST_WB_TBL;
        ST_WB_TBL: if (mem_ack_i) state_q <= ST_RESP;
        ST_RESP:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_paddr_o  = paddr_q;
  assign rsp_fault_o  = fault_q;
  assign fault_addr_o = fault_addr_q;

  assert_entry_align_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ENTRY_SH-1:0] == '0))
    else $error("R1 misaligned entry address");

  assert_fault_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (fault_addr_o == vaddr_q))
    else $error("R7 fault address not loaded");

  assert_wb_sets_acc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[BIT_ACCESSED])
    else $error("R9 write-back without accessed flag");

  assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o)
    else $error("R10 ready high after accept");

  assert_rsp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o)
    else $error("R10 response longer than one cycle");
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        paging_en_i = 1'b1, protect_en_i = 1'b1, wp_en_i = 1'b0;
  logic [19:0] dir_base_i = 20'h0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_user_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_fault_o;
  logic [31:0] rsp_paddr_o, fault_addr_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  pt_walker i_pt_walker (.*);

  // memory model: 16 KB, one-cycle acknowledge
  logic [31:0] mem [4096];
  int          wr_cnt = 0, log_n = 0;
  logic [31:0] addr_log [4];

  always @(posedge clk_i) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= mem[mem_addr_o[13:2]];
      if (mem_we_o) begin
        mem[mem_addr_o[13:2]] <= mem_wdata_o;
        wr_cnt = wr_cnt + 1;
      end
      if (log_n < 4) addr_log[log_n] <= mem_addr_o;
      log_n = log_n + 1;
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic bit perm_bad(input logic [31:0] e, input bit wr, input bit us, input bit wp);
    return !e[0] || e[7] || (us && !e[2]) || (wr && !e[1] && (us || wp));
  endfunction

  logic [31:0] exp_fa = '0;

  task automatic run(input logic [31:0] va, input bit wr, input bit us, input string tag);
    logic [31:0] da, ta, de, te, exp_pa;
    bit          exp_f;
    int          exp_wr, exp_rq, t;
    da = {dir_base_i, 12'h000} + {20'h0, va[31:22], 2'b00};
    de = mem[da[13:2]];
    ta = {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    te = mem[ta[13:2]];
    exp_wr = 0;
    if (!(paging_en_i && protect_en_i)) begin
      exp_f = 0; exp_pa = va; exp_rq = 0;
    end else if (perm_bad(de, wr, us, wp_en_i)) begin
      exp_f = 1; exp_pa = 0; exp_rq = 1;
    end else if (perm_bad(te, wr, us, wp_en_i)) begin
      exp_f = 1; exp_pa = 0; exp_rq = 2;
    end else begin
      exp_f = 0; exp_pa = {te[31:12], va[11:0]};
      exp_wr = int'(!de[5]) + int'(!te[5]);
      exp_rq = 2 + exp_wr;
    end
    if (exp_f) exp_fa = va;
    @(negedge clk_i);
    wr_cnt = 0; log_n = 0;
    req_vaddr_i = va; req_write_i = wr; req_user_i = us; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " R10 ready low while busy"}, 32'(req_ready_o), 32'd0);
    t = 0;
    while (!rsp_valid_o && t < 50) begin @(negedge clk_i); t++; end
    chk({tag, " R10 response seen"}, 32'(rsp_valid_o), 32'd1);
    chk({tag, " R3 fault flag"}, 32'(rsp_fault_o), 32'(exp_f));
    chk({tag, " R2 paddr"}, rsp_paddr_o, exp_pa);
    chk({tag, " R7 fault_addr"}, fault_addr_o, exp_fa);
    @(negedge clk_i);
    chk({tag, " R10 single pulse"}, 32'(rsp_valid_o), 32'd0);
    chk({tag, " R8 memory accesses"}, 32'(log_n), 32'(exp_rq));
    chk({tag, " R9 write-backs"}, 32'(wr_cnt), 32'(exp_wr));
    if (exp_rq >= 1) chk({tag, " R1 dir entry addr"}, addr_log[0], da);
    if (exp_rq >= 2) chk({tag, " R1 table entry addr"}, addr_log[1], ta);
    if (exp_rq >= 2 && !exp_f) begin
      chk({tag, " R9 dir entry after"}, mem[da[13:2]], de | 32'h20);
      chk({tag, " R9 table entry after"}, mem[ta[13:2]], te | 32'h20);
      if (exp_wr == 2) chk({tag, " R9 dir written first"}, addr_log[2], da);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R10 reset ready", 32'(req_ready_o), 32'd1);
    chk("R10 reset rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R7 reset fault_addr", fault_addr_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle no memory request", 32'(mem_req_o), 32'd0);

    // directed corner cases
    mem[1024*0 + 8]  = 32'h0000_1007;             // dir 8 -> table 0x1000, A clear
    mem[1024*1 + 5]  = 32'hABCD_E007;             // table entry, A clear
    run(32'h0200_5123, 0, 0, "R2 R9 first walk");
    run(32'h0200_5123, 1, 1, "R9 accessed already set");
    mem[9]           = 32'h0000_2006;             // dir not present
    run(32'h0240_07FF, 0, 0, "R3 dir absent");
    run(32'h0200_5ABC, 0, 0, "R7 success keeps fault_addr");
    mem[10]          = 32'h0000_2027;
    mem[2048 + 3]    = 32'h5555_5006;             // table not present
    run(32'h0280_3000, 0, 0, "R3 table absent");
    mem[11]          = 32'h0000_20A7;             // reserved bit 7 in dir
    mem[2048 + 1]    = 32'h1234_5027;
    run(32'h02C0_1004, 0, 0, "R4 reserved dir");
    mem[12]          = 32'h0000_3027;
    mem[3072 + 2]    = 32'h1111_1023;             // supervisor-only page
    run(32'h0300_2010, 0, 1, "R5 user to supervisor page");
    run(32'h0300_2010, 0, 0, "R5 supervisor read ok");
    mem[13]          = 32'h0000_3027;
    mem[3072 + 4]    = 32'h2222_2025;             // read-only page
    wp_en_i = 1'b0;
    run(32'h0340_4444, 1, 0, "R6 supervisor write wp off");
    run(32'h0340_4444, 1, 1, "R6 user write read-only");
    wp_en_i = 1'b1;
    run(32'h0340_4444, 1, 0, "R6 supervisor write wp on");
    mem[3072 + 5]    = 32'h3333_30A7;             // reserved bit in table entry
    run(32'h0340_5000, 0, 0, "R4 reserved table");
    wp_en_i = 1'b0;
    paging_en_i = 1'b0;
    run(32'hDEAD_BEEF, 1, 1, "R8 paging off");
    paging_en_i = 1'b1; protect_en_i = 1'b0;
    run(32'h0200_5123, 0, 0, "R8 protection off");
    protect_en_i = 1'b1;

    // constrained random
    for (int i = 0; i < 8; i++)
      mem[i] = {18'h0, 2'($urandom_range(1, 3)), 12'h0} |
               {24'h0, ($urandom_range(0, 15) == 0), 1'b0, 1'($urandom), 2'b00,
                1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0)};
    for (int i = 1024; i < 4096; i++)
      mem[i] = {20'($urandom), 4'h0, ($urandom_range(0, 15) == 0), 1'b0, 1'($urandom), 2'b00,
                1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0)};
    for (int k = 0; k < 400; k++) begin
      logic [31:0] va;
      va = {7'h0, 3'($urandom), 22'($urandom)};
      wp_en_i      = 1'($urandom);
      paging_en_i  = ($urandom_range(0, 9) != 0);
      protect_en_i = ($urandom_range(0, 9) != 0);
      run(va, 1'($urandom), 1'($urandom), "random R2 R3 R4 R5 R6");
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule